// File: doc/BRIEF.md
# Serial Block Receive Buffer with Checksum Gate

This block sits on the device side of a storage controller. It takes a serial bit stream from the medium, one qualified bit per clock, and hunts for an 8-bit sync pattern. After the pattern it captures an 8-bit block identifier. It then packs the payload bits into a local buffer of 16 words of 16 bits. The block ends with a 16-bit checksum word, which is compared against the running sum of the payload.

Only a block whose checksum matches is released. The ready output then works as the "buffer filled" interrupt, telling a processor or DMA engine that data may be read out. The reader drains the buffer one word per request, and each word comes with a single-cycle acknowledge.

A mismatching block raises an error flag instead of ready. That flag holds until software clears it.

Top module: `blkbuf_rx`

## Requirements
- R1: After reset, `buf_ready`, `sum_err` and `xfer_ack` are all low, and `blk_id` reads zero.
- R2: While hunting, serial bits are shifted through an 8-bit window, most significant bit first. A block starts only when the last eight qualified bits equal 8'hB4. Any bits before that are discarded.
- R3: The 8 qualified bits that follow the sync pattern are the block identifier, MSB first. They appear on `blk_id` from the cycle after the last identifier bit is taken.
- R4: The payload is 16 words of 16 bits, each MSB first, followed by a 16-bit checksum word. If the checksum equals the sum of the 16 payload words modulo 2^16, `buf_ready` goes high in the cycle after the last checksum bit is taken.
- R5: If the checksum does not match, `sum_err` goes high in the cycle after the last checksum bit and `buf_ready` stays low. The two flags are never high together.
- R6: While `sum_err` is high, requests get no acknowledge and the flag holds. A cycle with `err_clr` high drops the flag in the next cycle and restarts the sync hunt.
- R7: While ready, a request sampled high at an edge with no acknowledge pending gives `xfer_ack` high for exactly one cycle after that edge. In that same cycle `word_out` carries the next payload word, in arrival order.
- R8: A request raised while the buffer is not ready receives no acknowledge. It is acknowledged in the cycle after the buffer becomes ready.
- R9: `buf_ready` falls in the same cycle as the 16th acknowledge, and the block then hunts for the next sync pattern.
- R10: Serial bits that arrive while the buffer is ready do not change the buffered words or `blk_id`.
- R11: A request held high continuously is acknowledged every other cycle, so `xfer_ack` is never high in two adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_valid | input | 1 | Qualifies `ser_bit` in this cycle |
| ser_bit | input | 1 | Serial data bit from the medium |
| xfer_req | input | 1 | Word transfer request from the reader |
| err_clr | input | 1 | Clears the checksum error flag |
| buf_ready | output | 1 | Buffer filled and verified (interrupt) |
| sum_err | output | 1 | Checksum mismatch flag |
| blk_id | output | 8 | Captured block identifier |
| xfer_ack | output | 1 | One-cycle acknowledge for a delivered word |
| word_out | output | 16 | Word delivered with the acknowledge |

## Verification
All results come one clock edge after the stimulus that causes them:
- `blk_id` follows the edge that takes the last identifier bit.
- `buf_ready` or `sum_err` follows the edge that takes the last checksum bit.
- `xfer_ack` and `word_out` follow the edge that samples the request.
- A cleared error drops one edge after `err_clr`.

The bench changes inputs on falling edges and reads outputs on the next falling edge. Every check therefore lands exactly one rising edge after its cause. The held-request and early-request cases check the off cycles as explicitly as the on cycles.

// File: rtl/blkbuf_pkg.sv
package blkbuf_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_ID,
        ST_DATA,
        ST_SUM,
        ST_READY,
        ST_BAD
    } rx_state_e;

    localparam int DEF_WORD_W  = 16;
    localparam int DEF_N_WORDS = 16;
    localparam int DEF_ID_W    = 8;
    localparam int DEF_SYNC_W  = 8;

endpackage

// File: rtl/blkbuf_sync_det.sv
module blkbuf_sync_det #(
    parameter int              SYNC_W   = 8,
    parameter logic [SYNC_W-1:0] SYNC_PAT = 8'hB4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic bit_in,
    output logic hit
);
    logic [SYNC_W-1:0] win_d, win_q;
    logic [SYNC_W-1:0] win_nx;

    always_comb begin
        win_nx = {win_q[SYNC_W-2:0], bit_in};
        hit    = en && (win_nx == SYNC_PAT);
        win_d  = win_q;
        if (clr || hit) begin
            win_d = '0;
        end else if (en) begin
            win_d = win_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end
endmodule

// File: rtl/blkbuf_sum_acc.sv
module blkbuf_sum_acc #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add,
    input  logic [WORD_W-1:0] val,
    output logic [WORD_W-1:0] sum
);
    logic [WORD_W-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr)      acc_d = '0;
        else if (add) acc_d = acc_q + val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign sum = acc_q;
endmodule

// File: rtl/blkbuf_store.sv
module blkbuf_store #(
    parameter int WORD_W  = 16,
    parameter int N_WORDS = 16,
    localparam int PTR_W  = $clog2(N_WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem_q [N_WORDS];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/blkbuf_rx.sv
module blkbuf_rx
    import blkbuf_pkg::*;
#(
    parameter int                WORD_W   = DEF_WORD_W,
    parameter int                N_WORDS  = DEF_N_WORDS,
    parameter int                ID_W     = DEF_ID_W,
    parameter int                SYNC_W   = DEF_SYNC_W,
    parameter logic [SYNC_W-1:0] SYNC_PAT = 8'hB4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_valid,
    input  logic              ser_bit,
    input  logic              xfer_req,
    input  logic              err_clr,
    output logic              buf_ready,
    output logic              sum_err,
    output logic [ID_W-1:0]   blk_id,
    output logic              xfer_ack,
    output logic [WORD_W-1:0] word_out
);
    localparam int MAXB  = (WORD_W > ID_W) ? WORD_W : ID_W;
    localparam int CNT_W = $clog2(MAXB);
    localparam int PTR_W = $clog2(N_WORDS);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(N_WORDS - 1);
    localparam logic [CNT_W-1:0] LAST_ID  = CNT_W'(ID_W - 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shr;
        logic [PTR_W-1:0]  wp;
        logic [PTR_W-1:0]  rp;
        logic [ID_W-1:0]   id;
        logic              ack;
        logic [WORD_W-1:0] dout;
    } regs_t;

    regs_t r_d, r_q;

    logic              sync_hit;
    logic              acc_clr, acc_add;
    logic [WORD_W-1:0] acc_sum;
    logic              mem_we;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] shr_nx;

    blkbuf_sync_det #(.SYNC_W(SYNC_W), .SYNC_PAT(SYNC_PAT)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ser_valid && (r_q.st == ST_HUNT)),
        .clr    (r_q.st != ST_HUNT),
        .bit_in (ser_bit),
        .hit    (sync_hit)
    );

    blkbuf_sum_acc #(.WORD_W(WORD_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .add   (acc_add),
        .val   (shr_nx),
        .sum   (acc_sum)
    );

    blkbuf_store #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (r_q.wp),
        .wdata (shr_nx),
        .raddr (r_q.rp),
        .rdata (rd_word)
    );

    always_comb begin
        r_d     = r_q;
        r_d.ack = 1'b0;
        acc_clr = 1'b0;
        acc_add = 1'b0;
        mem_we  = 1'b0;
        shr_nx  = {r_q.shr[WORD_W-2:0], ser_bit};

        unique case (r_q.st)
            ST_HUNT: begin
                if (sync_hit) begin
                    r_d.st  = ST_ID;
                    r_d.cnt = '0;
                    r_d.wp  = '0;
                    acc_clr = 1'b1;
                end
            end
            ST_ID: begin
                if (ser_valid) begin
                    r_d.shr = shr_nx;
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                    if (r_q.cnt == LAST_ID) begin
                        r_d.id  = shr_nx[ID_W-1:0];
                        r_d.cnt = '0;
                        r_d.st  = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (ser_valid) begin
                    r_d.shr = shr_nx;
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                    if (r_q.cnt == LAST_BIT) begin
                        r_d.cnt = '0;
                        mem_we  = 1'b1;
                        acc_add = 1'b1;
                        r_d.wp  = r_q.wp + PTR_W'(1);
                        if (r_q.wp == LAST_PTR) r_d.st = ST_SUM;
                    end
                end
            end
            ST_SUM: begin
                if (ser_valid) begin
                    r_d.shr = shr_nx;
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                    if (r_q.cnt == LAST_BIT) begin
                        r_d.cnt = '0;
                        r_d.rp  = '0;
                        r_d.st  = (shr_nx == acc_sum) ? ST_READY : ST_BAD;
                    end
                end
            end
            ST_READY: begin
                if (xfer_req && !r_q.ack) begin
                    r_d.ack  = 1'b1;
                    r_d.dout = rd_word;
                    r_d.rp   = r_q.rp + PTR_W'(1);
                    if (r_q.rp == LAST_PTR) r_d.st = ST_HUNT;
                end
            end
            ST_BAD: begin
                if (err_clr) r_d.st = ST_HUNT;
            end
            default: r_d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_HUNT, cnt: '0, shr: '0, wp: '0, rp: '0,
                     id: '0, ack: 1'b0, dout: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign buf_ready = (r_q.st == ST_READY);
    assign sum_err   = (r_q.st == ST_BAD);
    assign blk_id    = r_q.id;
    assign xfer_ack  = r_q.ack;
    assign word_out  = r_q.dout;
endmodule

// File: rtl/blkbuf_rx_chk.sv
module blkbuf_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic ser_valid,
    input logic xfer_req,
    input logic err_clr,
    input logic buf_ready,
    input logic sum_err,
    input logic xfer_ack
);
    // R4: a verified block is released only by an incoming bit
    a_r4_ready_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_ready) |-> $past(ser_valid));

    // R5: ready and error flags are exclusive
    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_ready && sum_err));

    // R6: no acknowledge while in error
    a_r6_no_ack_in_err: assert property (@(posedge clk) disable iff (!rst_n)
        sum_err |-> !xfer_ack);

    // R6: error holds until cleared
    a_r6_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_err && !err_clr) |=> sum_err);

    // R7: every acknowledge answers a request
    a_r7_ack_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack |-> $past(xfer_req));

    // R8: acknowledge only from a ready buffer
    a_r8_ack_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack |-> $past(buf_ready));

    // R11: acknowledges are never back to back
    a_r11_ack_gap: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack |=> !xfer_ack);
endmodule

bind blkbuf_rx blkbuf_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_valid (ser_valid),
    .xfer_req  (xfer_req),
    .err_clr   (err_clr),
    .buf_ready (buf_ready),
    .sum_err   (sum_err),
    .xfer_ack  (xfer_ack)
);

// File: tb/blkbuf_rx_bench.sv
`timescale 1ns/1ps
module blkbuf_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_valid = 1'b0;
    logic        ser_bit = 1'b0;
    logic        xfer_req = 1'b0;
    logic        err_clr = 1'b0;
    logic        buf_ready;
    logic        sum_err;
    logic [7:0]  blk_id;
    logic        xfer_ack;
    logic [15:0] word_out;

    int total = 0;
    int bad = 0;
    logic [15:0] exp_w [16];

    localparam logic [7:0] SYNC = 8'hB4;

    always #4 clk = ~clk;

    blkbuf_rx u_blkbuf_rx (
        .clk(clk), .rst_n(rst_n), .ser_valid(ser_valid), .ser_bit(ser_bit),
        .xfer_req(xfer_req), .err_clr(err_clr), .buf_ready(buf_ready),
        .sum_err(sum_err), .blk_id(blk_id), .xfer_ack(xfer_ack), .word_out(word_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_valid = 1'b1;
            ser_bit   = v[i];
        end
    endtask

    task automatic send_frame(input logic [7:0] id, input logic [15:0] seed, input bit corrupt);
        logic [15:0] s;
        s = '0;
        for (int i = 0; i < 16; i++) begin
            exp_w[i] = (16'h0111 * 16'(i + 1)) ^ seed;
            s = s + exp_w[i];
        end
        if (corrupt) s = s ^ 16'h0040;
        send_bits({8'h00, SYNC}, 8);
        send_bits({8'h00, id}, 8);
        for (int i = 0; i < 16; i++) send_bits(exp_w[i], 16);
        send_bits(s, 16);
        @(negedge clk);
        ser_valid = 1'b0;
    endtask

    task automatic drain(input int first);
        for (int i = first; i < 16; i++) begin
            @(negedge clk);
            chk(xfer_ack == 1'b0, "R11 idle before request", xfer_ack, 0);
            xfer_req = 1'b1;
            @(negedge clk);
            xfer_req = 1'b0;
            chk(xfer_ack == 1'b1, "R7 ack", xfer_ack, 1);
            chk(word_out == exp_w[i], "R7 word order", word_out, exp_w[i]);
            if (i == 15) chk(buf_ready == 1'b0, "R9 ready drops on last ack", buf_ready, 0);
            else         chk(buf_ready == 1'b1, "R9 ready held mid-drain", buf_ready, 1);
        end
    endtask

    task automatic t_reset;
        chk(buf_ready == 1'b0, "R1 ready", buf_ready, 0);
        chk(sum_err == 1'b0, "R1 err", sum_err, 0);
        chk(xfer_ack == 1'b0, "R1 ack", xfer_ack, 0);
        chk(blk_id == 8'h00, "R1 id", blk_id, 0);
    endtask

    task automatic t_good_with_junk;
        send_bits(16'h0038, 6); // 111000, no sync inside
        chk(buf_ready == 1'b0, "R2 no start on junk", buf_ready, 0);
        send_frame(8'h3C, 16'h5A00, 1'b0);
        chk(buf_ready == 1'b1, "R4 ready after good block", buf_ready, 1);
        chk(sum_err == 1'b0, "R4 no error", sum_err, 0);
        chk(blk_id == 8'h3C, "R3 block id", blk_id, 8'h3C);
        drain(0);
    endtask

    task automatic t_early_request;
        @(negedge clk);
        xfer_req = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(xfer_ack == 1'b0, "R8 held off while not ready", xfer_ack, 0);
        end
        send_frame(8'hC7, 16'h13F0, 1'b0);
        chk(buf_ready == 1'b1, "R8 ready", buf_ready, 1);
        chk(xfer_ack == 1'b0, "R8 no ack in ready cycle", xfer_ack, 0);
        @(negedge clk);
        xfer_req = 1'b0;
        chk(xfer_ack == 1'b1, "R8 ack after ready", xfer_ack, 1);
        chk(word_out == exp_w[0], "R8 first word", word_out, exp_w[0]);
        chk(blk_id == 8'hC7, "R3 second id", blk_id, 8'hC7);
        drain(1);
    endtask

    task automatic t_held_request;
        send_frame(8'h81, 16'hFFFF, 1'b0);
        @(negedge clk);
        xfer_req = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (k % 2 == 0) begin
                chk(xfer_ack == 1'b1, "R11 ack on", xfer_ack, 1);
                chk(word_out == exp_w[k / 2], "R11 word", word_out, exp_w[k / 2]);
            end else begin
                chk(xfer_ack == 1'b0, "R11 ack gap", xfer_ack, 0);
            end
        end
        xfer_req = 1'b0;
        drain(3);
    endtask

    task automatic t_bad_sum;
        send_frame(8'h55, 16'h0F0F, 1'b1);
        chk(sum_err == 1'b1, "R5 error flag", sum_err, 1);
        chk(buf_ready == 1'b0, "R5 not ready", buf_ready, 0);
        xfer_req = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(xfer_ack == 1'b0, "R6 no ack in error", xfer_ack, 0);
        end
        xfer_req = 1'b0;
        chk(sum_err == 1'b1, "R6 error holds", sum_err, 1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk(sum_err == 1'b0, "R6 error cleared", sum_err, 0);
        send_frame(8'h2E, 16'h7001, 1'b0);
        chk(buf_ready == 1'b1, "R6 hunt resumes", buf_ready, 1);
        drain(0);
    endtask

    task automatic t_ignore_serial;
        send_frame(8'h9D, 16'hA5C3, 1'b0);
        send_bits({8'h00, SYNC}, 8);
        send_bits(16'h1234, 16);
        send_bits(16'hFEDC, 16);
        @(negedge clk);
        ser_valid = 1'b0;
        chk(buf_ready == 1'b1, "R10 still ready", buf_ready, 1);
        chk(blk_id == 8'h9D, "R10 id unchanged", blk_id, 8'h9D);
        drain(0);
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_good_with_junk();
        t_early_request();
        t_held_request();
        t_bad_sum();
        t_ignore_serial();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule